// File: doc/BRIEF.md
# Four-Way Set-Associative Data Cache with Way Lockdown

This block sits between a load/store requester and a word-wide memory. It keeps lines of eight 32-bit words in a four-way set-associative array and services loads from that array with one cycle of latency when the line is present. On a load miss it asks memory for the line starting at the word that was requested. Memory returns the words in wrapped order, and the load completes as soon as that first word arrives. The rest of the line keeps streaming into the array after the load has completed.

Each store carries a policy bit. In write-back mode a hit only updates the array and marks the modified half of the line. In write-through mode a hit updates the array and also sends the word to memory. Stores that miss never allocate: they go straight to memory. Each line keeps one modified flag per four-word half. When a line is replaced, only the flagged halves are streamed out on the write-back port, and this happens before the new line is fetched.

A lockdown mask removes ways from allocation without hiding the lines already in them. A single pulse on the invalidate input drops every line, including modified ones.

Top module: `dcache_lockdown`

## Requirements
- R1: A load that hits is accepted in one cycle, raises `rsp_valid` with the word on the next cycle, and causes no memory traffic.
- R2: On a load miss, `req_ready` stays low and `fill_req` is held high. `fill_addr` is the byte address of the requested word. Memory returns the eight words of the line starting at that word and wrapping modulo 8. The load's data is the first returned word, and it appears on `rsp_valid` one cycle after that beat is consumed.
- R3: A write-back store (`req_wthru`=0) that hits updates the cached word and produces no memory write and no response. Later loads return the new value, and memory receives it only on eviction.
- R4: A write-through store (`req_wthru`=1) that hits updates the cached word and issues exactly one write on the memory write port, one cycle after acceptance.
- R5: A store that misses, under either policy, issues exactly one memory write and allocates no line, so a following load to that line misses.
- R6: The victim on a load miss is the first way that is not locked, searching upward from a shared round-robin pointer (which is 0 after reset) and wrapping. Once a victim is allocated, the pointer moves to the way after it.
- R7: Setting bit w of `lock_mask` keeps way w from being chosen as a victim. A line already in a locked way still returns hits.
- R8: When all four ways are locked, a load miss is still served with correct data, but nothing is allocated, so repeating the load misses again.
- R9: A victim with modified halves is written out on `wb_valid`/`wb_addr`/`wb_data` before `fill_req` rises. Each flagged four-word half (words 0–3 or 4–7) is sent as four consecutive words in ascending order. A clean half is skipped, and a clean victim produces no write-back.
- R10: A one-cycle pulse on `inv_all` while the cache is idle invalidates every line and discards modified data without writing it back. `req_ready` is low during the pulse.
- R11: After reset every line is invalid, `req_ready` is high, and `rsp_valid`, `fill_req`, `wb_valid` and `mem_wr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted this cycle when high together with `req_valid` |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wthru | input | 1 | Store policy: 1 = write-through, 0 = write-back |
| req_addr | input | 16 | Byte address; bits [4:2] word, [6:5] set, [15:7] tag |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Load data valid (one-cycle pulse) |
| rsp_rdata | output | 32 | Load data |
| lock_mask | input | 4 | One bit per way; set = excluded from allocation |
| inv_all | input | 1 | Invalidate every line |
| fill_req | output | 1 | Line fetch in progress |
| fill_addr | output | 16 | Byte address of the first (requested) word of the fetch |
| fill_valid | input | 1 | Fill beat present |
| fill_data | input | 32 | Fill word, in wrapped order |
| wb_valid | output | 1 | Write-back word valid |
| wb_addr | output | 16 | Byte address of the write-back word |
| wb_data | output | 32 | Write-back word |
| mem_wr_valid | output | 1 | Single-word memory write (write-through hit or store miss) |
| mem_wr_addr | output | 16 | Memory write byte address |
| mem_wr_data | output | 32 | Memory write data |

## Verification
The main sequence is a table of accesses confined to one set.

- It first fills all four ways, so the round-robin victim order is visible through which later loads miss again.
- It mixes write-back and write-through hits, so memory contents after an eviction show which policy actually deferred the write.
- It places the first load at a middle word, so a line-aligned fetch cannot be mistaken for a wrapped one.

Directed cases then look at lockdown:

- Some ways locked, to separate "locked ways still hit" from "locked ways never evicted".
- All ways locked, where a repeated miss proves that nothing was allocated.

Eviction is tried with:

- both halves dirty (eight words),
- only the upper half dirty (four words starting at word 4),
- a clean victim (none).

Finally, a dirty line is invalidated, and the reload must return the old memory value.

// File: rtl/dc_pkg.sv
package dc_pkg;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 32;
    localparam int WAYS     = 4;
    localparam int SETS     = 4;
    localparam int WORDS    = 8;
    localparam int BYTE_W   = 2;
    localparam int WSEL_W   = $clog2(WORDS);
    localparam int IDX_W    = $clog2(SETS);
    localparam int WAY_W    = $clog2(WAYS);
    localparam int TAG_W    = ADDR_W - BYTE_W - WSEL_W - IDX_W;
    localparam int LINE_LSB = BYTE_W + WSEL_W;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        tag_t              tag;
        logic [IDX_W-1:0]  idx;
        logic [WSEL_W-1:0] word;
    } lad_t;

    typedef enum logic [1:0] {ST_IDLE, ST_EVICT, ST_FILL} st_e;

    function automatic lad_t split_addr(input logic [ADDR_W-1:0] a);
        return lad_t'(a[ADDR_W-1:BYTE_W]);
    endfunction

    function automatic logic half_of(input logic [WSEL_W-1:0] w);
        return w[WSEL_W-1];
    endfunction
endpackage

// File: rtl/dc_tag_match.sv
module dc_tag_match
    import dc_pkg::*;
(
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0]            way_vld,
    input  tag_t                       req_tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] match;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = way_vld[g] && (way_tag[g] == req_tag);
    end

    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/dc_victim_sel.sv
module dc_victim_sel
    import dc_pkg::*;
(
    input  logic [WAY_W-1:0] rr_ptr,
    input  logic [WAYS-1:0]  locked,
    output logic             any_free,
    output logic [WAY_W-1:0] victim
);
    logic [WAY_W-1:0] cand;

    always_comb begin
        any_free = 1'b0;
        victim   = rr_ptr;
        cand     = rr_ptr;
        for (int k = WAYS - 1; k >= 0; k--) begin
            cand = rr_ptr + WAY_W'(k);
            if (!locked[cand]) begin
                any_free = 1'b1;
                victim   = cand;
            end
        end
    end
endmodule

// File: rtl/dcache_lockdown.sv
module dcache_lockdown
    import dc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_wthru,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [WAYS-1:0]   lock_mask,
    input  logic              inv_all,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data
);
    // storage
    tag_t             tag_q [WAYS][SETS];
    word_t            dat_q [WAYS][SETS][WORDS];
    logic [WAYS-1:0]  vld_q [SETS];
    logic [1:0]       dty_q [WAYS][SETS];

    // control state
    st_e               st;
    lad_t              cur;
    logic [WAY_W-1:0]  vic;
    logic              alloc;
    logic [WSEL_W-1:0] beat;
    logic [WSEL_W-1:0] ev_cnt;
    logic [WSEL_W-1:0] ev_end;
    logic [WAY_W-1:0]  rr;

    // lookup
    lad_t                       rf;
    logic [WAYS-1:0][TAG_W-1:0] way_tag;
    logic                       hit;
    logic [WAY_W-1:0]           hit_way;
    logic                       any_free;
    logic [WAY_W-1:0]           vsel;
    logic                       accept;

    assign rf        = split_addr(req_addr);
    assign req_ready = (st == ST_IDLE) && !inv_all;
    assign accept    = req_valid && req_ready;

    always_comb begin
        for (int w = 0; w < WAYS; w++) way_tag[w] = tag_q[w][rf.idx];
    end

    dc_tag_match u_match (
        .way_tag (way_tag),
        .way_vld (vld_q[rf.idx]),
        .req_tag (rf.tag),
        .hit     (hit),
        .hit_way (hit_way)
    );

    dc_victim_sel u_vsel (
        .rr_ptr   (rr),
        .locked   (lock_mask),
        .any_free (any_free),
        .victim   (vsel)
    );

    // array write port
    logic              fill_beat, fill_last, dat_we, tag_we;
    logic [WAY_W-1:0]  dw_way;
    logic [IDX_W-1:0]  dw_idx;
    logic [WSEL_W-1:0] dw_word;
    word_t             dw_data;

    assign fill_beat = (st == ST_FILL) && fill_valid;
    assign fill_last = fill_beat && (beat == WSEL_W'(WORDS - 1));
    assign dat_we    = (accept && req_write && hit) || (fill_beat && alloc);
    assign tag_we    = fill_last && alloc;
    assign dw_way    = (st == ST_FILL) ? vic : hit_way;
    assign dw_idx    = (st == ST_FILL) ? cur.idx : rf.idx;
    assign dw_word   = (st == ST_FILL) ? cur.word + beat : rf.word;
    assign dw_data   = (st == ST_FILL) ? fill_data : req_wdata;

    always_ff @(posedge clk) begin
        if (dat_we) dat_q[dw_way][dw_idx][dw_word] <= dw_data;
        if (tag_we) tag_q[vic][cur.idx] <= cur.tag;
    end

    // memory-side outputs
    assign fill_req  = (st == ST_FILL);
    assign fill_addr = {cur, {BYTE_W{1'b0}}};
    assign wb_valid  = (st == ST_EVICT);
    assign wb_addr   = {tag_q[vic][cur.idx], cur.idx, ev_cnt, {BYTE_W{1'b0}}};
    assign wb_data   = dat_q[vic][cur.idx][ev_cnt];

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= ST_IDLE;
            rsp_valid    <= 1'b0;
            mem_wr_valid <= 1'b0;
            rr           <= '0;
            alloc        <= 1'b0;
            beat         <= '0;
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) dty_q[w][s] <= '0;
            end
        end else begin
            rsp_valid    <= 1'b0;
            mem_wr_valid <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (inv_all) begin
                        for (int s = 0; s < SETS; s++) begin
                            vld_q[s] <= '0;
                            for (int w = 0; w < WAYS; w++) dty_q[w][s] <= '0;
                        end
                    end else if (accept && !req_write) begin
                        if (hit) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= dat_q[hit_way][rf.idx][rf.word];
                        end else begin
                            cur   <= rf;
                            beat  <= '0;
                            alloc <= any_free;
                            vic   <= vsel;
                            st    <= ST_FILL;
                            if (any_free) begin
                                vld_q[rf.idx][vsel] <= 1'b0;
                                dty_q[vsel][rf.idx] <= '0;
                                rr <= vsel + WAY_W'(1);
                                if (dty_q[vsel][rf.idx] != 2'b00) begin
                                    st     <= ST_EVICT;
                                    ev_cnt <= dty_q[vsel][rf.idx][0] ? '0 : WSEL_W'(WORDS / 2);
                                    ev_end <= dty_q[vsel][rf.idx][1] ? WSEL_W'(WORDS - 1)
                                                                     : WSEL_W'(WORDS / 2 - 1);
                                end
                            end
                        end
                    end else if (accept) begin
                        if (hit && !req_wthru) begin
                            dty_q[hit_way][rf.idx][half_of(rf.word)] <= 1'b1;
                        end else begin
                            mem_wr_valid <= 1'b1;
                            mem_wr_addr  <= req_addr;
                            mem_wr_data  <= req_wdata;
                        end
                    end
                end
                ST_EVICT: begin
                    if (ev_cnt == ev_end) st <= ST_FILL;
                    else                  ev_cnt <= ev_cnt + WSEL_W'(1);
                end
                ST_FILL: begin
                    if (fill_valid) begin
                        beat <= beat + WSEL_W'(1);
                        if (beat == '0) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= fill_data;
                        end
                        if (fill_last) begin
                            st <= ST_IDLE;
                            if (alloc) vld_q[cur.idx][vic] <= 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dc_checker.sv
module dc_checker
    import dc_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic                       req_write,
    input logic                       rsp_valid,
    input logic                       fill_req,
    input logic [ADDR_W-1:0]          fill_addr,
    input logic                       wb_valid,
    input logic [ADDR_W-LINE_LSB-1:0] wb_line,
    input logic                       mem_wr_valid
);
    // R9: write-back and line fetch never overlap
    assert_no_wb_during_fill_R9: assert property (@(posedge clk) disable iff (rst)
        !(fill_req && wb_valid));

    // R9: one eviction burst stays on a single line
    assert_wb_same_line_R9: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && $past(wb_valid)) |-> (wb_line == $past(wb_line)));

    // R2: requester stalled while a fetch is outstanding
    assert_stall_on_fill_R2: assert property (@(posedge clk) disable iff (rst)
        fill_req |-> !req_ready);

    // R2: fetch address held for the whole fetch
    assert_fill_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (fill_req && $past(fill_req)) |-> $stable(fill_addr));

    // R3: stores never produce a load response
    assert_store_no_rsp_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write) |=> !rsp_valid);

    // R11: quiet outputs right after reset
    assert_idle_after_reset_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rsp_valid && !fill_req && !wb_valid && !mem_wr_valid && req_ready));
endmodule

bind dcache_lockdown dc_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_write    (req_write),
    .rsp_valid    (rsp_valid),
    .fill_req     (fill_req),
    .fill_addr    (fill_addr),
    .wb_valid     (wb_valid),
    .wb_line      (wb_addr[dc_pkg::ADDR_W-1:dc_pkg::LINE_LSB]),
    .mem_wr_valid (mem_wr_valid)
);

// File: tb/sim_dcache_lockdown.sv
`timescale 1ns/1ps
module sim_dcache_lockdown;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wthru = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic [3:0]  lock_mask = '0;
    logic        inv_all = 1'b0;
    logic        fill_req, fill_valid = 1'b0;
    logic [15:0] fill_addr;
    logic [31:0] fill_data = '0;
    logic        wb_valid, mem_wr_valid;
    logic [15:0] wb_addr, mem_wr_addr;
    logic [31:0] wb_data, mem_wr_data;

    always #2.5 clk = ~clk;

    dcache_lockdown u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_wthru(req_wthru), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .lock_mask(lock_mask), .inv_all(inv_all), .fill_req(fill_req),
        .fill_addr(fill_addr), .fill_valid(fill_valid), .fill_data(fill_data),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    int checks = 0, bad = 0;
    int n_fill = 0, n_wb = 0, n_mw = 0;
    logic [13:0] first_fill = '0;
    logic [15:0] first_wb = '0;
    logic        wb_prev = 1'b0;
    logic [31:0] mem [int];

    function automatic logic [31:0] memrd(input int wa);
        if (mem.exists(wa)) return mem[wa];
        return 32'h5A00_0000 | wa;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
        end
    endtask

    // memory-side monitors
    always @(negedge clk) begin
        if (wb_valid) begin
            n_wb++;
            if (!wb_prev) first_wb = wb_addr;
            mem[int'(wb_addr[15:2])] = wb_data;
        end
        wb_prev = wb_valid;
        if (mem_wr_valid) begin
            n_mw++;
            mem[int'(mem_wr_addr[15:2])] = mem_wr_data;
        end
    end

    // line fetch responder: wrapped order from the requested word
    initial begin
        forever begin
            @(negedge clk);
            if (fill_req) begin
                int wa;
                wa = int'(fill_addr[15:2]);
                n_fill++;
                first_fill = fill_addr[15:2];
                for (int b = 0; b < 8; b++) begin
                    fill_valid = 1'b1;
                    fill_data  = memrd((wa & ~7) | ((wa + b) & 7));
                    @(negedge clk);
                end
                fill_valid = 1'b0;
            end
        end
    end

    task automatic do_access(input int op, input logic [15:0] a, input logic [31:0] wd,
                             input logic [31:0] ex, input int nf, input int nw,
                             input int nm, input string rq);
        int f0, w0, m0, lat;
        logic [31:0] got;
        f0 = n_fill; w0 = n_wb; m0 = n_mw; got = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = (op != 0); req_wthru = (op == 2);
        req_addr = a; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        if (op == 0) begin
            while (!rsp_valid) begin @(negedge clk); lat++; end
            got = rsp_rdata;
        end
        while (!req_ready) @(negedge clk);
        repeat (2) @(negedge clk);
        #1;
        if (op == 0) chk(got == ex, rq, "load data", got, ex);
        chk(n_fill - f0 == nf, rq, "line fetches", n_fill - f0, nf);
        chk(n_wb - w0 == nw, rq, "write-back words", n_wb - w0, nw);
        chk(n_mw - m0 == nm, rq, "memory writes", n_mw - m0, nm);
        if (op == 0 && nf == 0) chk(lat == 1, "R1", "hit latency", lat, 1);
        if (op == 0 && nf != 0) chk(first_fill == a[15:2], "R2", "critical word first",
                                    {18'b0, first_fill}, {18'b0, a[15:2]});
    endtask

    typedef struct packed {
        logic [1:0]  op;     // 0 load, 1 write-back store, 2 write-through store
        logic [15:0] addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [3:0]  nfill;
        logic [3:0]  nwb;
        logic [3:0]  nmw;
    } vec_t;

    // all in set 0; tag t at byte address t*0x80
    localparam vec_t VEC [13] = '{
        '{2'd0, 16'h008C, 32'h0,         32'h5A000023, 4'd1, 4'd0, 4'd0},
        '{2'd0, 16'h0094, 32'h0,         32'h5A000025, 4'd0, 4'd0, 4'd0},
        '{2'd1, 16'h0084, 32'hDEAD0001,  32'h0,        4'd0, 4'd0, 4'd0},
        '{2'd0, 16'h0084, 32'h0,         32'hDEAD0001, 4'd0, 4'd0, 4'd0},
        '{2'd2, 16'h0098, 32'hBEEF0006,  32'h0,        4'd0, 4'd0, 4'd1},
        '{2'd0, 16'h0098, 32'h0,         32'hBEEF0006, 4'd0, 4'd0, 4'd0},
        '{2'd1, 16'h0100, 32'h12340000,  32'h0,        4'd0, 4'd0, 4'd1},
        '{2'd0, 16'h0100, 32'h0,         32'h12340000, 4'd1, 4'd0, 4'd0},
        '{2'd0, 16'h0180, 32'h0,         32'h5A000060, 4'd1, 4'd0, 4'd0},
        '{2'd0, 16'h0200, 32'h0,         32'h5A000080, 4'd1, 4'd0, 4'd0},
        '{2'd0, 16'h0280, 32'h0,         32'h5A0000A0, 4'd1, 4'd4, 4'd0},
        '{2'd0, 16'h0084, 32'h0,         32'hDEAD0001, 4'd1, 4'd0, 4'd0},
        '{2'd0, 16'h0098, 32'h0,         32'hBEEF0006, 4'd0, 4'd0, 4'd0}
    };

    task automatic summary();
        $display("test done: total=%0d bad=%0d", checks, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; bad++;
        $display("FAIL R11 watchdog act=hung exp=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk(req_ready == 1'b1, "R11", "req_ready", req_ready, 1);
        chk({rsp_valid, fill_req, wb_valid, mem_wr_valid} == 4'b0, "R11", "idle outputs",
            {rsp_valid, fill_req, wb_valid, mem_wr_valid}, 0);

        // table walk: fill one set, policies, round-robin (R6) eviction
        for (int i = 0; i < 13; i++) begin
            string rq;
            vec_t v;
            v = VEC[i];
            if (v.op == 0)      rq = (v.nfill != 0) ? ((v.nwb != 0) ? "R9" : "R6") : "R1";
            else if (v.op == 1) rq = (v.nmw != 0) ? "R5" : "R3";
            else                rq = "R4";
            do_access(int'(v.op), v.addr, v.wd, v.exp, int'(v.nfill), int'(v.nwb),
                      int'(v.nmw), rq);
        end
        // set 0 now: way0 t5, way1 t1, way2 t3, way3 t4, pointer at 2

        // R7: only way 0 allocatable
        @(negedge clk); lock_mask = 4'b1110;
        do_access(0, 16'h0180, 0, 32'h5A000060, 0, 0, 0, "R7");
        do_access(0, 16'h0300, 0, 32'h5A0000C0, 1, 0, 0, "R6");
        do_access(0, 16'h0284, 0, 32'h5A0000A1, 1, 0, 0, "R7");
        do_access(0, 16'h0200, 0, 32'h5A000080, 0, 0, 0, "R7");

        // R8: everything locked
        @(negedge clk); lock_mask = 4'b1111;
        do_access(0, 16'h0380, 0, 32'h5A0000E0, 1, 0, 0, "R8");
        do_access(0, 16'h0384, 0, 32'h5A0000E1, 1, 0, 0, "R8");
        do_access(0, 16'h0284, 0, 32'h5A0000A1, 0, 0, 0, "R8");

        // R9: both halves dirty -> eight words
        do_access(1, 16'h0280, 32'h11110000, 0, 0, 0, 0, "R3");
        do_access(1, 16'h029C, 32'h22220007, 0, 0, 0, 0, "R3");
        @(negedge clk); lock_mask = 4'b1110;
        do_access(0, 16'h0300, 0, 32'h5A0000C0, 1, 8, 0, "R9");
        chk(first_wb == 16'h0280, "R9", "first write-back address", first_wb, 16'h0280);
        do_access(0, 16'h029C, 0, 32'h22220007, 1, 0, 0, "R9");
        do_access(0, 16'h0280, 0, 32'h11110000, 0, 0, 0, "R9");

        // R9: only upper half dirty -> four words from word 4
        do_access(1, 16'h0294, 32'h33330005, 0, 0, 0, 0, "R3");
        do_access(0, 16'h0300, 0, 32'h5A0000C0, 1, 4, 0, "R9");
        chk(first_wb == 16'h0290, "R9", "upper-half write-back start", first_wb, 16'h0290);
        do_access(0, 16'h0294, 0, 32'h33330005, 1, 0, 0, "R9");

        // R10: invalidate drops a dirty line
        @(negedge clk); lock_mask = 4'b0000;
        do_access(0, 16'h0184, 0, 32'h5A000061, 0, 0, 0, "R10");
        do_access(1, 16'h0184, 32'h77777777, 0, 0, 0, 0, "R10");
        @(negedge clk); inv_all = 1'b1;
        #1 chk(req_ready == 1'b0, "R10", "ready during invalidate", req_ready, 0);
        @(negedge clk); inv_all = 1'b0;
        do_access(0, 16'h0184, 0, 32'h5A000061, 1, 0, 0, "R10");
        do_access(0, 16'h0200, 0, 32'h5A000080, 1, 0, 0, "R10");

        summary();
        $finish;
    end
endmodule